// File: doc/BRIEF.md
# Picture-in-Picture Window Compositor

This block merges two pixel streams into one displayed stream. Both streams already share the output raster. One is the main channel and the other is the video channel. A single swap bit decides which of the two supplies the overlay picture; the other one becomes the background. The block receives the raster position as x/y counters, together with data-enable, horizontal sync and vertical sync. It emits the composed pixel two clock cycles later, with the three timing signals delayed by the same amount.

Up to sixteen rectangular windows can be placed anywhere on the raster, and each has its own enable bit. A window may sit inside the main picture, overlap its edge, or lie entirely outside it. A live-window select names the one window that carries real-time overlay video. Every other enabled window is painted in a programmable placeholder colour, because the block holds no frame memory. All window coordinates snap to a 4-pixel grid.

Window rectangles are written through a small write port into shadow storage. That storage, together with the enable mask, the live select, the swap bit and the placeholder colour, moves into the working set only when vertical sync rises. A frame therefore never shows a half-applied configuration.

Top module: `pip_compositor`

## Requirements
- R1: The outputs pix_out, de_out, hs_out and vs_out reflect the inputs of exactly two clock cycles earlier. While reset is active and straight after it, all four outputs are zero.
- R2: When the delayed data-enable is low, pix_out is all zeros.
- R3: An active pixel that no enabled window covers shows the background. With swap=0 the background is main_pix; with swap=1 it is vid_pix.
- R4: An active pixel whose winning window equals the live select shows the overlay source. With swap=0 that is vid_pix; with swap=1 it is main_pix.
- R5: An active pixel whose winning window is enabled but is not the live window shows the placeholder colour.
- R6: A window whose enable bit is 0 has no effect on any pixel, and it is never chosen as the winner.
- R7: Window i covers the pixels with floor(X/4)*4 <= x < floor(X/4)*4 + floor(W/4)*4, and the same relation for y using Y and H. The low two bits of X, Y, W and H are ignored. A width or height below 4 gives an empty window.
- R8: Where enabled windows overlap, the window with the lowest index wins, and at most one window is granted per pixel.
- R9: A rectangle write (cfg_we with cfg_idx) and changes to cfg_en, cfg_live, cfg_swap and cfg_fill take effect only after the next rising edge of vs_in. Frames that have no vs_in rise keep the old configuration.
- R10: Any part of a window that falls outside the active area, where de_in is low, is clipped. Only the part inside the active area is drawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | XW | Raster column counter |
| y_in | input | YW | Raster line counter |
| de_in | input | 1 | Active-area data enable |
| hs_in | input | 1 | Horizontal sync |
| vs_in | input | 1 | Vertical sync; its rising edge commits the configuration |
| main_pix | input | PW | Main channel pixel |
| vid_pix | input | PW | Video channel pixel |
| cfg_we | input | 1 | Write strobe for one window rectangle (shadow) |
| cfg_idx | input | IW | Index of the window being written |
| cfg_x | input | XW | Window left edge (low two bits ignored) |
| cfg_y | input | YW | Window top edge (low two bits ignored) |
| cfg_w | input | XW | Window width (low two bits ignored) |
| cfg_h | input | YW | Window height (low two bits ignored) |
| cfg_en | input | NWIN | Per-window enable mask |
| cfg_live | input | IW | Index of the live window |
| cfg_swap | input | 1 | 0: overlay comes from video; 1: overlay comes from main |
| cfg_fill | input | PW | Placeholder colour for enabled windows that are not live |
| pix_out | output | PW | Composed pixel |
| de_out | output | 1 | Data enable delayed by two cycles |
| hs_out | output | 1 | Horizontal sync delayed by two cycles |
| vs_out | output | 1 | Vertical sync delayed by two cycles |

## Verification
The assertions assume that vs_in rises only at a frame boundary, with de_in low for the rest of that line. They also assume that a rectangle write never lands in the same cycle as a vs_in rise, so the working set never changes while an active pixel is being classified. The stimulus follows these rules by construction. It drives a regular raster whose vertical sync occupies the first, blank line of each frame, and it issues every configuration write in idle blank cycles between frames. Window rectangles are chosen with unaligned low bits and with edges that cross the active border, so the bench covers the snapping and clipping rules while staying within those input rules.

// File: rtl/pip_pkg.sv
`timescale 1ns/1ps
package pip_pkg;
  // Widest coordinate the compare functions handle; XW and YW must not exceed it.
  localparam int CW = 16;

  // Source chosen for one output pixel.
  typedef enum logic [1:0] {
    SRC_BLANK = 2'd0,
    SRC_BACK  = 2'd1,
    SRC_OVL   = 2'd2,
    SRC_FILL  = 2'd3
  } pix_src_e;

  // Clear the two low bits so a coordinate lands on the 4-pixel grid.
  function automatic logic [CW-1:0] snap4(input logic [CW-1:0] v);
    return {v[CW-1:2], 2'b00};
  endfunction

  // True when position p lies in the grid-aligned span [org, org+len).
  function automatic logic in_span(input logic [CW-1:0] p,
                                   input logic [CW-1:0] org,
                                   input logic [CW-1:0] len);
    logic [CW:0] lo;
    logic [CW:0] hi;
    lo = {1'b0, snap4(org)};
    hi = lo + {1'b0, snap4(len)};
    return ({1'b0, p} >= lo) && ({1'b0, p} < hi);
  endfunction
endpackage

// File: rtl/pip_win_bank.sv
`timescale 1ns/1ps
// Shadow and working copies of the window configuration.
module pip_win_bank #(
  parameter int NWIN = 16,
  parameter int XW   = 12,
  parameter int YW   = 12,
  parameter int PW   = 24,
  parameter int IW   = $clog2(NWIN)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      vs_in,
  input  logic                      cfg_we,
  input  logic [IW-1:0]             cfg_idx,
  input  logic [XW-1:0]             cfg_x,
  input  logic [YW-1:0]             cfg_y,
  input  logic [XW-1:0]             cfg_w,
  input  logic [YW-1:0]             cfg_h,
  input  logic [NWIN-1:0]           cfg_en,
  input  logic [IW-1:0]             cfg_live,
  input  logic                      cfg_swap,
  input  logic [PW-1:0]             cfg_fill,
  output logic [NWIN-1:0][XW-1:0]   wk_x,
  output logic [NWIN-1:0][YW-1:0]   wk_y,
  output logic [NWIN-1:0][XW-1:0]   wk_w,
  output logic [NWIN-1:0][YW-1:0]   wk_h,
  output logic [NWIN-1:0]           wk_en,
  output logic [IW-1:0]             wk_live,
  output logic                      wk_swap,
  output logic [PW-1:0]             wk_fill,
  output logic                      vs_rise
);
  logic vs_q;

  always_ff @(posedge clk) begin
    if (rst) vs_q <= 1'b0;
    else     vs_q <= vs_in;
  end

  assign vs_rise = vs_in & ~vs_q;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    logic [XW-1:0] sh_x, sh_w;
    logic [YW-1:0] sh_y, sh_h;
    logic          sel;

    assign sel = cfg_we && (cfg_idx == IW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        sh_x <= '0; sh_y <= '0; sh_w <= '0; sh_h <= '0;
      end else if (sel) begin
        sh_x <= cfg_x; sh_y <= cfg_y; sh_w <= cfg_w; sh_h <= cfg_h;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        wk_x[i] <= '0; wk_y[i] <= '0; wk_w[i] <= '0; wk_h[i] <= '0;
      end else if (vs_rise) begin
        wk_x[i] <= sh_x; wk_y[i] <= sh_y; wk_w[i] <= sh_w; wk_h[i] <= sh_h;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wk_en   <= '0;
      wk_live <= '0;
      wk_swap <= 1'b0;
      wk_fill <= '0;
    end else if (vs_rise) begin
      wk_en   <= cfg_en;
      wk_live <= cfg_live;
      wk_swap <= cfg_swap;
      wk_fill <= cfg_fill;
    end
  end
endmodule

// File: rtl/pip_win_match.sv
`timescale 1ns/1ps
// Per-window hit test and lowest-index priority pick.
module pip_win_match
  import pip_pkg::*;
#(
  parameter int NWIN = 16,
  parameter int XW   = 12,
  parameter int YW   = 12,
  parameter int IW   = $clog2(NWIN)
) (
  input  logic [XW-1:0]           x_in,
  input  logic [YW-1:0]           y_in,
  input  logic [NWIN-1:0][XW-1:0] wk_x,
  input  logic [NWIN-1:0][YW-1:0] wk_y,
  input  logic [NWIN-1:0][XW-1:0] wk_w,
  input  logic [NWIN-1:0][YW-1:0] wk_h,
  input  logic [NWIN-1:0]         wk_en,
  output logic [NWIN-1:0]         hit,
  output logic [NWIN-1:0]         grant,
  output logic                    win_any,
  output logic [IW-1:0]           win_idx
);
  for (genvar i = 0; i < NWIN; i++) begin : g_hit
    assign hit[i] = wk_en[i]
                 && in_span(CW'(x_in), CW'(wk_x[i]), CW'(wk_w[i]))
                 && in_span(CW'(y_in), CW'(wk_y[i]), CW'(wk_h[i]));
  end

  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win_any = 1'b1;
        win_idx = IW'(i);
      end
    end
  end

  assign grant = win_any ? (NWIN'(1) << win_idx) : '0;
endmodule

// File: rtl/pip_mix.sv
`timescale 1ns/1ps
// Two-stage output path: stage 1 classifies, stage 2 selects the pixel.
module pip_mix
  import pip_pkg::*;
#(
  parameter int PW = 24,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          de_in,
  input  logic          hs_in,
  input  logic          vs_in,
  input  logic [PW-1:0] main_pix,
  input  logic [PW-1:0] vid_pix,
  input  logic          swap,
  input  logic [PW-1:0] fill,
  input  logic          win_any,
  input  logic [IW-1:0] win_idx,
  input  logic [IW-1:0] live,
  output logic [PW-1:0] pix_out,
  output logic          de_out,
  output logic          hs_out,
  output logic          vs_out
);
  pix_src_e      src_d, s1_src;
  logic [PW-1:0] s1_bg, s1_ov, s1_fill;
  logic          s1_de, s1_hs, s1_vs;
  logic [PW-1:0] pix_d;

  always_comb begin
    if (!de_in)                src_d = SRC_BLANK;
    else if (!win_any)         src_d = SRC_BACK;
    else if (win_idx == live)  src_d = SRC_OVL;
    else                       src_d = SRC_FILL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_src <= SRC_BLANK;
      s1_bg  <= '0; s1_ov <= '0; s1_fill <= '0;
      s1_de  <= 1'b0; s1_hs <= 1'b0; s1_vs <= 1'b0;
    end else begin
      s1_src  <= src_d;
      s1_bg   <= swap ? vid_pix  : main_pix;
      s1_ov   <= swap ? main_pix : vid_pix;
      s1_fill <= fill;
      s1_de   <= de_in; s1_hs <= hs_in; s1_vs <= vs_in;
    end
  end

  always_comb begin
    case (s1_src)
      SRC_BACK: pix_d = s1_bg;
      SRC_OVL:  pix_d = s1_ov;
      SRC_FILL: pix_d = s1_fill;
      default:  pix_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_out <= '0; de_out <= 1'b0; hs_out <= 1'b0; vs_out <= 1'b0;
    end else begin
      pix_out <= pix_d; de_out <= s1_de; hs_out <= s1_hs; vs_out <= s1_vs;
    end
  end
endmodule

// File: rtl/pip_compositor.sv
`timescale 1ns/1ps
module pip_compositor #(
  parameter int NWIN = 16,
  parameter int XW   = 12,
  parameter int YW   = 12,
  parameter int PW   = 24,
  parameter int IW   = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XW-1:0]   x_in,
  input  logic [YW-1:0]   y_in,
  input  logic            de_in,
  input  logic            hs_in,
  input  logic            vs_in,
  input  logic [PW-1:0]   main_pix,
  input  logic [PW-1:0]   vid_pix,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_idx,
  input  logic [XW-1:0]   cfg_x,
  input  logic [YW-1:0]   cfg_y,
  input  logic [XW-1:0]   cfg_w,
  input  logic [YW-1:0]   cfg_h,
  input  logic [NWIN-1:0] cfg_en,
  input  logic [IW-1:0]   cfg_live,
  input  logic            cfg_swap,
  input  logic [PW-1:0]   cfg_fill,
  output logic [PW-1:0]   pix_out,
  output logic            de_out,
  output logic            hs_out,
  output logic            vs_out
);
  logic [NWIN-1:0][XW-1:0] wk_x, wk_w;
  logic [NWIN-1:0][YW-1:0] wk_y, wk_h;
  logic [NWIN-1:0]         wk_en;
  logic [IW-1:0]           wk_live;
  logic                    wk_swap;
  logic [PW-1:0]           wk_fill;
  logic                    vs_rise;
  logic [NWIN-1:0]         hit, grant;
  logic                    win_any;
  logic [IW-1:0]           win_idx;

  pip_win_bank #(.NWIN(NWIN), .XW(XW), .YW(YW), .PW(PW), .IW(IW)) u_bank (
    .clk(clk), .rst(rst), .vs_in(vs_in),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_x(cfg_x), .cfg_y(cfg_y),
    .cfg_w(cfg_w), .cfg_h(cfg_h), .cfg_en(cfg_en), .cfg_live(cfg_live),
    .cfg_swap(cfg_swap), .cfg_fill(cfg_fill),
    .wk_x(wk_x), .wk_y(wk_y), .wk_w(wk_w), .wk_h(wk_h), .wk_en(wk_en),
    .wk_live(wk_live), .wk_swap(wk_swap), .wk_fill(wk_fill), .vs_rise(vs_rise)
  );

  pip_win_match #(.NWIN(NWIN), .XW(XW), .YW(YW), .IW(IW)) u_match (
    .x_in(x_in), .y_in(y_in),
    .wk_x(wk_x), .wk_y(wk_y), .wk_w(wk_w), .wk_h(wk_h), .wk_en(wk_en),
    .hit(hit), .grant(grant), .win_any(win_any), .win_idx(win_idx)
  );

  pip_mix #(.PW(PW), .IW(IW)) u_mix (
    .clk(clk), .rst(rst), .de_in(de_in), .hs_in(hs_in), .vs_in(vs_in),
    .main_pix(main_pix), .vid_pix(vid_pix), .swap(wk_swap), .fill(wk_fill),
    .win_any(win_any), .win_idx(win_idx), .live(wk_live),
    .pix_out(pix_out), .de_out(de_out), .hs_out(hs_out), .vs_out(vs_out)
  );
endmodule

// File: rtl/pip_checker.sv
`timescale 1ns/1ps
module pip_checker #(
  parameter int NWIN = 16,
  parameter int PW   = 24,
  parameter int IW   = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            de_in,
  input logic            hs_in,
  input logic            vs_in,
  input logic [PW-1:0]   pix_out,
  input logic            de_out,
  input logic            hs_out,
  input logic            vs_out,
  input logic            vs_rise,
  input logic [NWIN-1:0] grant,
  input logic            win_any,
  input logic [IW-1:0]   win_idx,
  input logic [NWIN-1:0] wk_en,
  input logic [IW-1:0]   wk_live
);
  // Cycles since reset release, saturating; guards the two-deep history.
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (rst)            cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  a_r1_de_delay: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2) |-> (de_out == $past(de_in, 2)));
  a_r1_hs_delay: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2) |-> (hs_out == $past(hs_in, 2)));
  a_r1_vs_delay: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2) |-> (vs_out == $past(vs_in, 2)));
  a_r2_blank_zero: assert property (@(posedge clk) disable iff (rst)
    !de_out |-> (pix_out == '0));
  a_r8_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  a_r6_grant_enabled: assert property (@(posedge clk) disable iff (rst)
    win_any |-> wk_en[win_idx]);
  a_r9_hold_between_vsync: assert property (@(posedge clk) disable iff (rst)
    !vs_rise |=> ($stable(wk_en) && $stable(wk_live)));
endmodule

bind pip_compositor pip_checker #(.NWIN(NWIN), .PW(PW), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .de_in(de_in), .hs_in(hs_in), .vs_in(vs_in),
  .pix_out(pix_out), .de_out(de_out), .hs_out(hs_out), .vs_out(vs_out),
  .vs_rise(vs_rise), .grant(grant), .win_any(win_any), .win_idx(win_idx),
  .wk_en(wk_en), .wk_live(wk_live)
);

// File: tb/tb_pip_compositor.sv
`timescale 1ns/1ps
module tb_pip_compositor;
  localparam int NWIN = 4, XW = 8, YW = 8, PW = 24, IW = 2;
  localparam int H_TOT = 40, H_ACT = 32, V_TOT = 20, V_ACT = 16;

  logic clk = 0, rst = 1;
  logic [XW-1:0] x_in = '0;
  logic [YW-1:0] y_in = '0;
  logic de_in = 0, hs_in = 0, vs_in = 0;
  logic [PW-1:0] main_pix = '0, vid_pix = '0;
  logic cfg_we = 0;
  logic [IW-1:0] cfg_idx = '0, cfg_live = '0;
  logic [XW-1:0] cfg_x = '0, cfg_w = '0;
  logic [YW-1:0] cfg_y = '0, cfg_h = '0;
  logic [NWIN-1:0] cfg_en = '0;
  logic cfg_swap = 0;
  logic [PW-1:0] cfg_fill = 24'h00FF00;
  logic [PW-1:0] pix_out;
  logic de_out, hs_out, vs_out;

  always #5 clk = ~clk;

  pip_compositor #(.NWIN(NWIN), .XW(XW), .YW(YW), .PW(PW), .IW(IW)) dut (.*);

  int nchk = 0, nfail = 0;
  string scen = "R1 reset state";
  // Bench model: shadow and working configuration.
  int ms_x[NWIN], ms_y[NWIN], ms_w[NWIN], ms_h[NWIN];
  int mw_x[NWIN], mw_y[NWIN], mw_w[NWIN], mw_h[NWIN];
  bit [NWIN-1:0] mw_en = '0;
  int mw_live = 0;
  bit mw_swap = 0;
  logic [PW-1:0] mw_fill = '0;
  bit prev_vs = 0;
  // Expected-value pipeline, two deep.
  logic [PW-1:0] e1_pix = '0, e2_pix = '0;
  bit e1_de = 0, e2_de = 0, e1_hs = 0, e2_hs = 0, e1_vs = 0, e2_vs = 0;
  string e1_tag = "R1", e2_tag = "R1";

  task automatic tick(input int x, input int y, input bit de, input bit hs, input bit vs);
    int best;
    @(negedge clk);
    nchk++;
    if (pix_out !== e2_pix || de_out !== e2_de || hs_out !== e2_hs || vs_out !== e2_vs) begin
      nfail++;
      $display("FAIL %s [%s]: pix=%h exp=%h de=%b exp=%b hs=%b exp=%b vs=%b exp=%b",
               e2_tag, scen, pix_out, e2_pix, de_out, e2_de, hs_out, e2_hs, vs_out, e2_vs);
    end
    e2_pix = e1_pix; e2_de = e1_de; e2_hs = e1_hs; e2_vs = e1_vs; e2_tag = e1_tag;
    x_in = XW'(x); y_in = YW'(y); de_in = de; hs_in = hs; vs_in = vs;
    main_pix = {8'h3C, x_in, y_in};
    vid_pix  = {8'hC3, y_in, x_in};
    if (vs && !prev_vs) begin  // R9: commit on vsync rise only
      for (int i = 0; i < NWIN; i++) begin
        mw_x[i] = ms_x[i]; mw_y[i] = ms_y[i]; mw_w[i] = ms_w[i]; mw_h[i] = ms_h[i];
      end
      mw_en = cfg_en; mw_live = int'(cfg_live); mw_swap = cfg_swap; mw_fill = cfg_fill;
    end
    prev_vs = vs;
    best = -1;
    for (int i = NWIN - 1; i >= 0; i--) begin  // R7 grid, R8 lowest index wins
      int gx, gy, gw, gh;
      gx = (mw_x[i] / 4) * 4; gw = (mw_w[i] / 4) * 4;
      gy = (mw_y[i] / 4) * 4; gh = (mw_h[i] / 4) * 4;
      if (mw_en[i] && x >= gx && x < gx + gw && y >= gy && y < gy + gh) best = i;
    end
    e1_de = de; e1_hs = hs; e1_vs = vs;
    if (!de)                 begin e1_pix = '0; e1_tag = "R2"; end
    else if (best < 0)       begin e1_pix = mw_swap ? vid_pix : main_pix; e1_tag = "R3"; end
    else if (best == mw_live) begin e1_pix = mw_swap ? main_pix : vid_pix; e1_tag = "R4"; end
    else                     begin e1_pix = mw_fill; e1_tag = "R5"; end
  endtask

  task automatic idle();
    tick(0, 0, 0, 0, 0);
  endtask

  task automatic wr(input int idx, input int x, input int y, input int w, input int h);
    idle();
    cfg_we = 1; cfg_idx = IW'(idx);
    cfg_x = XW'(x); cfg_y = YW'(y); cfg_w = XW'(w); cfg_h = YW'(h);
    ms_x[idx] = x; ms_y[idx] = y; ms_w[idx] = w; ms_h[idx] = h;
    idle();
    cfg_we = 0;
  endtask

  task automatic run_frame(input bit with_vs);
    for (int ln = 0; ln < V_TOT; ln++) begin
      for (int c = 0; c < H_TOT; c++) begin
        bit act;
        act = (ln >= 2) && (ln < 2 + V_ACT) && (c < H_ACT);
        tick(c, (ln + 254) % 256, act, c < 4, with_vs && ln == 0);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < NWIN; i++) begin
      ms_x[i] = 0; ms_y[i] = 0; ms_w[i] = 0; ms_h[i] = 0;
      mw_x[i] = 0; mw_y[i] = 0; mw_w[i] = 0; mw_h[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: outputs zero out of reset, then two-cycle delay of all timing.
    repeat (4) idle();

    // R7 rectangles with unaligned low bits; R8 overlap of w0/w1; R10 w2 crosses edges.
    wr(0, 5, 6, 14, 9);    // x 4..15, y 4..11
    wr(1, 12, 8, 12, 8);   // x 12..23, y 8..15
    wr(2, 28, 13, 12, 8);  // x 28..39, y 12..19, clipped at x 32 and y 16
    wr(3, 0, 0, 40, 16);   // full-area window, kept disabled for R6
    scen = "R3 R6 main background, windows disabled";
    cfg_en = 4'b0000; cfg_swap = 0;
    run_frame(1); run_frame(1);

    scen = "R3 swapped background";
    cfg_swap = 1;
    run_frame(1);

    scen = "R4 R5 R6 R7 R8 R10 live w1, w3 disabled";
    cfg_en = 4'b0111; cfg_live = 2'd1; cfg_swap = 0;
    run_frame(1);

    scen = "R4 R5 R8 live w0 with swap";
    cfg_live = 2'd0; cfg_swap = 1;
    run_frame(1);

    scen = "R5 R8 all windows enabled, w3 lowest priority";
    cfg_en = 4'b1111; cfg_fill = 24'h123456; cfg_swap = 0;
    run_frame(1);

    scen = "R9 pending changes held without vsync";
    cfg_en = 4'b0011; cfg_live = 2'd1;
    wr(0, 0, 0, 8, 8);
    wr(1, 20, 2, 6, 6);
    run_frame(0);
    scen = "R9 pending changes applied after vsync";
    run_frame(1);

    scen = "R7 sub-grid width is empty";
    wr(0, 8, 8, 3, 12);
    cfg_en = 4'b0001; cfg_live = 2'd0;
    run_frame(1);

    repeat (4) idle();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #2000000;
    nfail++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule